// File: doc/BRIEF.md
# Eight-to-One Serializer with Bypass

This block turns a parallel word into a serial bit stream with a forwarded bit clock. It captures the word once per word-clock period and sends it out one bit at a time, least significant bit first. A word clock and its data are presented synchronously to a fast system clock `clk_i`, which runs at twice the bit rate and stands in for a multiplying PLL. Each bit therefore takes two `clk_i` cycles, and one word period is `2*W` cycles. The forwarded clock is low in the first half of each bit and high in the second half. The receiver samples on its rising edge, while the data is stable.

After an enable, or after leaving pass-through, a lock counter models the settling time of the multiplier. Words are not accepted until that interval ends. Two data-valid inputs are ANDed together; a word captured without both of them high is dropped. When no word is being shifted, the data and clock outputs rest high. A bypass select turns off the serial path and sends bit 0 of the data input and the word clock straight to the two outputs. When the enable is low, the outputs are released: a high-impedance flag is raised and both outputs are driven low. In that state all internal state is flushed.

A one-word holding register sits between capture and the shift register. With words arriving every `2*W` cycles, the stream has no gaps.

Top module: `ser8_bypass_tx`

## Requirements
- R1: After `rst_ni` is released or `en_i` rises with `bypass_i` low, both outputs stay high for at least `LOCK_CYCLES` (default 24) clock cycles. A word-clock edge during that interval never reaches the stream.
- R2: Each accepted word leaves least significant bit first. Each bit lasts two `clk_i` cycles. `ser_clk_o` is low for the first cycle of the bit and high for the second, and the data is unchanged across that rising edge.
- R3: A word is captured at the first `clk_i` edge that sees `wclk_i` high after a low sample. The rising edge of `ser_clk_o` for its bit 0 comes on the second or third `clk_i` edge after that capture edge.
- R4: Valid words whose word-clock rises are exactly `2*W` cycles apart come out back to back. Their first bits are also exactly `2*W` cycles apart, with no gap and no repeated word.
- R5: A word is accepted only when both bits of `dv_i` are high at the capture edge. Any other pattern (00, 01, 10) drops the word, and it never appears in the stream.
- R6: While no accepted word is being shifted, `ser_data_o` and `ser_clk_o` are both held at 1.
- R7: With `en_i` high and `bypass_i` high, `ser_data_o` equals `din_i[0]` and `ser_clk_o` equals `wclk_i` in the same cycle. `hiz_o` is 0, and `din_i[W-1:1]` and `dv_i` have no effect.
- R8: With `en_i` low, `hiz_o` is 1 and `ser_data_o` and `ser_clk_o` are 0, whatever the other inputs are.
- R9: Dropping `en_i`, or entering bypass, discards any captured or partly sent word and restarts the lock interval. A word captured just before the drop never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, twice the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable; low releases the outputs |
| bypass_i | input | 1 | Pass-through select |
| wclk_i | input | 1 | Word clock, synchronous to `clk_i` |
| din_i | input | W | Parallel data word |
| dv_i | input | 2 | Data-valid pair, ANDed |
| ser_data_o | output | 1 | Serial data |
| ser_clk_o | output | 1 | Forwarded bit clock |
| hiz_o | output | 1 | High-impedance flag |

## Verification
The bench sends all 256 word values back to back and rebuilds each one from the forwarded clock. A reversed bit order, or a shift-load that slipped by one bit, would corrupt words or change the measured latency and the word spacing. It issues a word during each lock window and one just before an enable drop. A design that skipped the lock or kept stale state would emit those words, and the bench flags them as unexpected. It also runs every non-valid pair of `dv_i` values, sweeps the data inputs in pass-through and with the enable low, and holds the outputs under watch while idle. This catches a single-input valid gate, a leaking upper data bit, and an output that does not park at the correct level.

// File: rtl/ser8_pkg.sv
package ser8_pkg;
  typedef enum logic [1:0] {
    PATH_OFF    = 2'd0,
    PATH_BYPASS = 2'd1,
    PATH_SERIAL = 2'd2
  } path_e;
endpackage

// File: rtl/ser8_lock_timer.sv
module ser8_lock_timer #(
  parameter int LOCK_CYCLES = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic locked_o
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LOCK_END = CW'(LOCK_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i)            cnt_q <= '0;
    else if (cnt_q != LOCK_END) cnt_q <= cnt_q + CW'(1);
  end

  assign locked_o = (cnt_q == LOCK_END);

  // R9
  lock_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !locked_o);
  // R1
  lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(run_i));
endmodule

// File: rtl/ser8_word_capture.sv
module ser8_word_capture #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         accept_i,
  input  logic         wclk_i,
  input  logic [W-1:0] din_i,
  input  logic [1:0]   dv_i,
  input  logic         take_i,
  output logic [W-1:0] word_o,
  output logic         vld_o
);
  logic wclk_q;
  logic rise;
  logic keep;

  assign rise = wclk_i & ~wclk_q;
  assign keep = accept_i & rise & (&dv_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wclk_q <= 1'b0;
      word_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      wclk_q <= wclk_i;
      if (!accept_i) begin
        vld_o <= 1'b0;
      end else if (keep) begin
        word_o <= din_i;
        vld_o  <= 1'b1;
      end else if (take_i) begin
        vld_o <= 1'b0;
      end
    end
  end

  // R5
  dv_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && rise && !(&dv_i) && !vld_o && !take_i) |=> !vld_o);
  // R9
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> !vld_o);
endmodule

// File: rtl/ser8_shifter.sv
module ser8_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         vld_i,
  input  logic [W-1:0] word_i,
  output logic         take_o,
  output logic         bit_o,
  output logic         clk_o
);
  localparam int BW = (W > 1) ? $clog2(W) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);

  logic          phase_q;
  logic          busy_q;
  logic [BW-1:0] cnt_q;
  logic [W-1:0]  sh_q;
  logic          free;

  // shift register may reload at the end of the last bit or while idle
  assign free   = !busy_q || (cnt_q == LAST_BIT);
  assign take_o = run_i && phase_q && free && vld_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
    end else if (!run_i) begin
      phase_q <= 1'b0;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      phase_q <= ~phase_q;
      if (phase_q) begin
        if (free) begin
          busy_q <= take_o;
          if (take_o) begin
            sh_q  <= word_i;
            cnt_q <= '0;
          end
        end else begin
          sh_q  <= sh_q >> 1;
          cnt_q <= cnt_q + BW'(1);
        end
      end
    end
  end

  assign bit_o = busy_q ? sh_q[0] : 1'b1;
  assign clk_o = busy_q ? phase_q : 1'b1;

  // R4
  full_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_q) && $past(run_i)) |-> ($past(cnt_q) == LAST_BIT));
  // R2
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && busy_q && !phase_q) |=> $stable(bit_o));
endmodule

// File: rtl/ser8_bypass_tx.sv
module ser8_bypass_tx
  import ser8_pkg::*;
#(
  parameter int W           = 8,
  parameter int LOCK_CYCLES = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bypass_i,
  input  logic         wclk_i,
  input  logic [W-1:0] din_i,
  input  logic [1:0]   dv_i,
  output logic         ser_data_o,
  output logic         ser_clk_o,
  output logic         hiz_o
);
  logic         run;
  logic         locked;
  logic         active;
  logic         take;
  logic         hold_vld;
  logic [W-1:0] hold_word;
  logic         sh_bit;
  logic         sh_clk;
  path_e        path;

  assign run    = en_i & ~bypass_i;
  assign active = run & locked;

  ser8_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .locked_o(locked)
  );

  ser8_word_capture #(.W(W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(active),
    .wclk_i  (wclk_i),
    .din_i   (din_i),
    .dv_i    (dv_i),
    .take_i  (take),
    .word_o  (hold_word),
    .vld_o   (hold_vld)
  );

  ser8_shifter #(.W(W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (active),
    .vld_i (hold_vld),
    .word_i(hold_word),
    .take_o(take),
    .bit_o (sh_bit),
    .clk_o (sh_clk)
  );

  always_comb begin
    if (!en_i)         path = PATH_OFF;
    else if (bypass_i) path = PATH_BYPASS;
    else               path = PATH_SERIAL;
  end

  always_comb begin
    unique case (path)
      PATH_OFF: begin
        ser_data_o = 1'b0;
        ser_clk_o  = 1'b0;
        hiz_o      = 1'b1;
      end
      PATH_BYPASS: begin
        ser_data_o = din_i[0];
        ser_clk_o  = wclk_i;
        hiz_o      = 1'b0;
      end
      default: begin
        ser_data_o = sh_bit;
        ser_clk_o  = sh_clk;
        hiz_o      = 1'b0;
      end
    endcase
  end

  // R1
  lock_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !locked) |-> (ser_clk_o && ser_data_o && !hiz_o));
  // R9
  relock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run) |-> !locked);
endmodule

// File: tb/ser8_bypass_tx_test.sv
module ser8_bypass_tx_test;
  localparam int W    = 8;
  localparam int LOCK = 24;
  localparam int PER  = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       byp = 1'b0;
  logic       wclk = 1'b0;
  logic [7:0] din = '0;
  logic [1:0] dv = '0;
  logic       ser_data, ser_clk, hiz;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int    exp_q[$];
  longint drv_q[$];
  longint prev_drv = -1;
  longint prev_first = -1;

  always #(PER/2) clk = ~clk;

  ser8_bypass_tx #(.W(W), .LOCK_CYCLES(LOCK)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .bypass_i(byp), .wclk_i(wclk),
    .din_i(din), .dv_i(dv), .ser_data_o(ser_data), .ser_clk_o(ser_clk), .hiz_o(hiz)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic got_word(input logic [7:0] w, input longint t_first);
    int e;
    longint td;
    longint lat;
    if (exp_q.size() == 0) begin
      check(0, "R5 unexpected word", w, -1);
      return;
    end
    e = exp_q.pop_front();
    td = drv_q.pop_front();
    check(w == e[7:0], "R2 word value", w, e);
    lat = (t_first - td) / PER;
    // R3: capture edge follows drive; bit0 rising seen 3 or 4 negedges later
    check(lat == 3 || lat == 4, "R3 first bit latency", lat, 3);
    if (prev_drv >= 0 && td - prev_drv == 2 * W * PER)
      check(t_first - prev_first == 2 * W * PER, "R4 back-to-back spacing",
            (t_first - prev_first) / PER, 2 * W);
    prev_drv = td;
    prev_first = t_first;
  endtask

  // deserializer on forwarded clock, sampled away from the clock edge
  logic       prev_c = 1'b1;
  int         nb = 0;
  logic [7:0] acc = '0;
  longint     t_first = 0;
  always @(negedge clk) begin
    #2;
    if (hiz || byp || !rst_n) begin
      prev_c = 1'b1;
      nb = 0;
    end else begin
      if (ser_clk && !prev_c) begin
        if (nb == 0) t_first = $time - 2;
        acc = {ser_data, acc[7:1]};
        nb++;
        if (nb == 8) begin
          nb = 0;
          got_word(acc, t_first);
        end
      end
      prev_c = ser_clk;
    end
  end

  task automatic check_high(input string req);
    check(ser_data && ser_clk && !hiz, req, {ser_data, ser_clk, hiz}, 3'b110);
  endtask

  task automatic send_word(input logic [7:0] w, input logic [1:0] d, input bit push, input bit chk_high);
    @(negedge clk);
    wclk = 1'b1; din = w; dv = d;
    if (push) begin
      exp_q.push_back(w);
      drv_q.push_back($time);
    end
    for (int k = 1; k < 2 * W; k++) begin
      @(negedge clk);
      if (k == W) wclk = 1'b0;
      if (chk_high) begin #2; check_high("R6 idle level with dv low"); end
    end
  endtask

  // one negedge after enable returns: stray word early, outputs must stay high
  task automatic lock_window(input string req);
    for (int k = 1; k < LOCK; k++) begin
      @(negedge clk);
      if (k == 1) begin wclk = 1'b1; din = 8'h5A; dv = 2'b11; end
      if (k == 1 + W) wclk = 1'b0;
      #2; check_high(req);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(PER * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2; check(hiz && !ser_data && !ser_clk, "R8 reset with enable low", hiz, 1);
    @(negedge clk); en = 1'b1;
    #2; check_high("R1 reset state enabled");
    @(negedge clk); rst_n = 1'b1;
    lock_window("R1 lock window after reset");

    // all word values back to back
    for (int w = 0; w < 256; w++) send_word(w[7:0], 2'b11, 1, 0);
    idle(3 * W);
    check(exp_q.size() == 0, "R2 all words delivered", exp_q.size(), 0);

    // data-valid patterns
    for (int i = 0; i < 16; i++) begin
      logic [1:0] p;
      p = (i % 4 == 0) ? 2'b11 : (i % 4 == 1) ? 2'b01 : (i % 4 == 2) ? 2'b10 : 2'b00;
      send_word(8'h3C ^ 8'(i * 17), p, p == 2'b11, 0);
    end
    idle(3 * W);
    send_word(8'hFF, 2'b01, 0, 1);
    send_word(8'h00, 2'b10, 0, 1);
    send_word(8'h81, 2'b00, 0, 1);
    check(exp_q.size() == 0, "R5 only valid words delivered", exp_q.size(), 0);

    // flush on enable drop
    @(negedge clk); wclk = 1'b1; din = 8'hE7; dv = 2'b11;
    @(negedge clk); en = 1'b0;
    #2; check(hiz && !ser_data && !ser_clk, "R8 outputs released", hiz, 1);
    @(negedge clk); en = 1'b1; wclk = 1'b0;
    lock_window("R9 relock after enable drop");
    for (int i = 0; i < 4; i++) send_word(8'h11 << i, 2'b11, 1, 0);
    idle(3 * W);
    check(exp_q.size() == 0, "R9 words after relock", exp_q.size(), 0);

    // pass-through sweep
    @(negedge clk); byp = 1'b1;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      din = i[7:0]; wclk = i[1] ^ i[3]; dv = i[1:0];
      #2;
      check(ser_data == din[0] && ser_clk == wclk && !hiz, "R7 bypass follow",
            {ser_data, ser_clk, hiz}, {din[0], wclk, 1'b0});
    end
    @(negedge clk); byp = 1'b0; wclk = 1'b0;
    lock_window("R9 relock after bypass");
    for (int i = 0; i < 8; i++) send_word(8'hA0 + 8'(i * 3), 2'b11, 1, 0);
    idle(3 * W);
    check(exp_q.size() == 0, "R2 words after bypass", exp_q.size(), 0);
    idle(4);
    #2; check_high("R6 idle level after stream");

    // enable low sweep
    @(negedge clk); en = 1'b0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      byp = i[0]; din = 8'(i * 37); dv = i[2:1]; wclk = i[3];
      #2;
      check(hiz && !ser_data && !ser_clk, "R8 enable low sweep",
            {ser_data, ser_clk, hiz}, 3'b001);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule